// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash bus. The program or erase command has already been sent to the device. A start pulse then hands the block a few things: whether the operation was a program or an erase, the word that was written, the address to watch, and which completion test to use. From that point the block issues one bus read after another to that address until the device reports that it is no longer busy.

Two completion tests are available. In the first, bit 7 of each read is compared with the value it will hold once the operation has finished. That value is the true bit 7 of the written word for a program, and 1 for an erase. In the second, the block watches bit 6, which flips on every read while the device is busy, and treats the operation as finished when two reads in a row return the same bit 6. Once completion is seen, the block makes one more read and returns that word with a single-cycle done pulse. If completion never appears within a set number of status reads, it pulses a timeout error and goes back to idle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, chip-enable and output-enable are high (inactive), and done and timeout are low.
- R2: Each bus read holds chip-enable and output-enable low together for exactly RD_CYCLES clocks, then high for at least one clock. The address presented is the one captured with start.
- R3: With bit-7 polling on a program (mode input 0, erase input 0), the status phase ends at the first read whose bit 7 equals bit 7 of the expected word.
- R4: With bit-7 polling on an erase (erase input 1), the status phase ends at the first read whose bit 7 is 1. The expected word is not used.
- R5: With bit-6 polling (mode input 1), the status phase ends at the first read whose bit 6 equals bit 6 of the read just before it in the same poll. The first read of a poll never ends it.
- R6: Polling needs no start-up delay: chip-enable goes low on the clock edge right after the edge that accepts start.
- R7: Once completion is detected, exactly one more read is made. Its word appears on the result output, and done is high for one clock. No further reads follow.
- R8: If MAX_POLLS status reads pass without completion, timeout is high for one clock, done stays low, and no further reads are made.
- R9: A start pulse that arrives while a poll is running is ignored: the running poll keeps its captured mode, operation, expected word and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a poll (accepted only when idle) |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program |
| use_toggle_i | input | 1 | 1 = bit-6 polling, 0 = bit-7 polling |
| exp_data_i | input | DW | Word that was programmed |
| poll_addr_i | input | AW | Address to read while polling |
| fl_ce_n_o | output | 1 | Flash chip-enable, active low |
| fl_oe_n_o | output | 1 | Flash output-enable, active low |
| fl_addr_o | output | AW | Flash address |
| fl_data_i | input | DW | Flash data bus |
| done_o | output | 1 | One-cycle pulse: operation complete |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached |
| result_o | output | DW | Word from the read after completion |

## Verification
The assertions rely on two things. The flash data bus must be stable during the last active clock of each read, and start must be a single-clock pulse whose operand inputs are valid in that same clock. The bench's flash model meets the first by setting the data word at the falling edge of chip-enable and holding it for the whole read. It drives start and its operands together at a falling clock edge. Busy reads always carry the wrong bit 7 and an alternating bit 6, while the other bits come from a random salt, so both completion tests see realistic busy traffic. A start injected in the middle of a poll carries different operands, which exercises the rule that such a start is ignored.

// File: rtl/flash_poll_pkg.sv
// Shared types for the flash completion polling controller.
package flash_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_FINAL = 2'd2
    } poll_state_e;
endpackage

// File: rtl/flash_read_cycle.sv
// Bus read sequencer: while en_i is high, runs back-to-back reads. Each read
// holds CE/OE low for RD_CYCLES clocks, then high for one clock.
// Assumes data_i is settled during the last active clock of each read.
module flash_read_cycle #(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int RD_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          ce_n_o,
    output logic          oe_n_o,
    output logic [AW-1:0] addr_o,
    output logic          rd_vld_o,
    output logic [DW-1:0] rd_data_o
);
    localparam int CW = (RD_CYCLES > 1) ? $clog2(RD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RD_CYCLES - 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic          last;

    // Final active clock of the current read.
    assign last = active && (cnt == LAST);

    // Active/idle phase and the width counter within a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (en_i) begin
            active <= 1'b1;
        end
    end

    // Bus strobes follow the active phase; data is taken on the last clock.
    assign ce_n_o    = ~active;
    assign oe_n_o    = ~active;
    assign addr_o    = addr_i;
    assign rd_vld_o  = last;
    assign rd_data_o = data_i;

    // R2: a read ends with strobes released for at least one clock
    p_gap_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld_o |=> ce_n_o && oe_n_o);
    // R2: strobes never release before RD_CYCLES clocks have passed
    p_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_o && !rd_vld_o) |=> !ce_n_o);
endmodule

// File: rtl/flash_done_judge.sv
// Completion decision for one status read. Bit-7 mode compares bit 7 with
// its finished value; bit-6 mode compares bit 6 with the previous read.
// Assumes prev_vld_i is low for the first read of a poll.
module flash_done_judge (
    input  logic use_toggle_i,
    input  logic op_erase_i,
    input  logic exp_bit7_i,
    input  logic prev_vld_i,
    input  logic prev_bit6_i,
    input  logic rd_bit7_i,
    input  logic rd_bit6_i,
    output logic complete_o
);
    logic target7;

    // Finished value of bit 7: written bit for a program, 1 for an erase.
    assign target7 = op_erase_i ? 1'b1 : exp_bit7_i;

    // Select the test that matches the polling mode.
    always_comb begin
        if (use_toggle_i)
            complete_o = prev_vld_i && (rd_bit6_i == prev_bit6_i);
        else
            complete_o = (rd_bit7_i == target7);
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
// Flash completion polling controller (top). Captures the operands on start,
// polls the flash until the chosen completion test passes or MAX_POLLS
// status reads have elapsed, then makes one further read and reports it.
// Assumes start_i is a one-clock pulse and the operands are valid with it.
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int RD_CYCLES = 2,
    parameter int MAX_POLLS = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_erase_i,
    input  logic          use_toggle_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic [AW-1:0] poll_addr_i,
    output logic          fl_ce_n_o,
    output logic          fl_oe_n_o,
    output logic [AW-1:0] fl_addr_o,
    input  logic [DW-1:0] fl_data_i,
    output logic          done_o,
    output logic          timeout_o,
    output logic [DW-1:0] result_o
);
    localparam int PCW = $clog2(MAX_POLLS + 1);
    localparam logic [PCW-1:0] LAST_POLL = PCW'(MAX_POLLS - 1);

    poll_state_e    state;
    logic           erase_q, toggle_q, exp7_q;
    logic [AW-1:0]  addr_q;
    logic [PCW-1:0] poll_cnt;
    logic           prev6, prev_vld;
    logic           rd_vld, complete;
    logic [DW-1:0]  rd_data;

    flash_read_cycle #(.AW(AW), .DW(DW), .RD_CYCLES(RD_CYCLES)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state != ST_IDLE),
        .addr_i   (addr_q),
        .data_i   (fl_data_i),
        .ce_n_o   (fl_ce_n_o),
        .oe_n_o   (fl_oe_n_o),
        .addr_o   (fl_addr_o),
        .rd_vld_o (rd_vld),
        .rd_data_o(rd_data)
    );

    flash_done_judge u_judge (
        .use_toggle_i(toggle_q),
        .op_erase_i  (erase_q),
        .exp_bit7_i  (exp7_q),
        .prev_vld_i  (prev_vld),
        .prev_bit6_i (prev6),
        .rd_bit7_i   (rd_data[7]),
        .rd_bit6_i   (rd_data[6]),
        .complete_o  (complete)
    );

    // Poll sequencing: capture, status reads, final read, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            erase_q   <= 1'b0;
            toggle_q  <= 1'b0;
            exp7_q    <= 1'b0;
            addr_q    <= '0;
            poll_cnt  <= '0;
            prev6     <= 1'b0;
            prev_vld  <= 1'b0;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            result_o  <= '0;
        end else begin
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    erase_q  <= op_erase_i;
                    toggle_q <= use_toggle_i;
                    exp7_q   <= exp_data_i[7];
                    addr_q   <= poll_addr_i;
                    poll_cnt <= '0;
                    prev_vld <= 1'b0;
                    state    <= ST_POLL;
                end
                ST_POLL: if (rd_vld) begin
                    prev6    <= rd_data[6];
                    prev_vld <= 1'b1;
                    if (complete) begin
                        state <= ST_FINAL;
                    end else if (poll_cnt == LAST_POLL) begin
                        timeout_o <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                ST_FINAL: if (rd_vld) begin
                    result_o <= rd_data;
                    done_o   <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: done is a one-clock pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7/R8: done and timeout never coincide
    p_done_xor_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));
    // R8: timeout only after the last permitted status read
    p_timeout_at_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> $past(poll_cnt) == LAST_POLL);
    // R9: captured operands hold while a poll runs
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(addr_q) && $stable(toggle_q) && $stable(erase_q));
    // R6: the first read begins one clock after start is accepted
    p_prompt_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i) |=> ##1 !fl_ce_n_o);
endmodule

// File: tb/test_flash_poll_ctrl.sv
// Bench: a behavioural flash model answers reads; expectations come from
// bench functions that apply the completion rules to the model's words.
module test_flash_poll_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20, DW = 16, RD = 3, MAXP = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, erase = 1'b0, toggle = 1'b0;
    logic [DW-1:0] exp_d = '0;
    logic [AW-1:0] addr = '0;
    logic ce_n, oe_n, done, tmo;
    logic [AW-1:0] fa;
    logic [DW-1:0] fdata = '0, result;

    int tests = 0, fails = 0, cyc = 0;
    int rd_idx = -1, lowlen = 0;
    int m_nbusy = 0;
    logic m_erase = 1'b0, m_toggle = 1'b0, m_phase = 1'b0;
    logic [DW-1:0] m_exp = '0, m_salt = '0;
    logic [AW-1:0] m_addr = '0;

    flash_poll_ctrl #(.AW(AW), .DW(DW), .RD_CYCLES(RD), .MAX_POLLS(MAXP)) i_flash_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_erase_i(erase),
        .use_toggle_i(toggle), .exp_data_i(exp_d), .poll_addr_i(addr),
        .fl_ce_n_o(ce_n), .fl_oe_n_o(oe_n), .fl_addr_o(fa), .fl_data_i(fdata),
        .done_o(done), .timeout_o(tmo), .result_o(result));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Word the model returns on read i of the current operation.
    function automatic logic [DW-1:0] model_word(input int i);
        logic [DW-1:0] w;
        if (i >= m_nbusy) return m_erase ? {DW{1'b1}} : m_exp;
        w = m_salt ^ DW'(i * 40503);
        w[7] = m_erase ? 1'b0 : ~m_exp[7];
        w[6] = i[0] ^ m_phase;
        return w;
    endfunction

    // Index of the status read that completes, or -1 for a timeout.
    function automatic int predict();
        logic p6 = 1'b0;
        for (int i = 0; i < MAXP; i++) begin
            logic [DW-1:0] w = model_word(i);
            if (m_toggle) begin
                if (i > 0 && w[6] == p6) return i;
            end else if (w[7] == (m_erase ? 1'b1 : m_exp[7])) return i;
            p6 = w[6];
        end
        return -1;
    endfunction

    // Flash model: each falling chip-enable starts a new read.
    always @(negedge ce_n) begin
        rd_idx = rd_idx + 1;
        fdata  = model_word(rd_idx);
    end

    // Bus monitor: strobe width and address for every read (R2).
    always @(negedge clk) if (rst_n) begin
        if (!ce_n) begin
            lowlen++;
            if (oe_n !== 1'b0 || fa !== m_addr)
                check(1'b0, "R2 strobe/address", int'(fa), int'(m_addr));
        end else if (lowlen > 0) begin
            check(lowlen == RD, "R2 read width", lowlen, RD);
            lowlen = 0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_op(input bit er, input bit tg, input logic [DW-1:0] ex,
                          input logic [AW-1:0] ad, input int nb, input bit inject);
        int k, exp_reads, waitc, reads_at_end;
        bit got_done = 0, got_tmo = 0;
        m_erase = er; m_toggle = tg; m_exp = ex; m_addr = ad; m_nbusy = nb;
        m_salt = DW'($urandom); m_phase = 1'($urandom);
        rd_idx = -1;
        k = predict();
        exp_reads = (k >= 0) ? k + 2 : MAXP;
        erase = er; toggle = tg; exp_d = ex; addr = ad; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(ce_n == 1'b0, "R6 first read prompt", ce_n, 0);
        waitc = 0;
        while (!done && !tmo && waitc < 2000) begin
            @(negedge clk); waitc++;
            if (inject && waitc == 4) begin
                erase = ~er; toggle = ~tg; exp_d = ~ex; addr = ~ad; start = 1'b1;
            end else start = 1'b0;
        end
        start = 1'b0;
        got_done = done; got_tmo = tmo;
        if (k >= 0) begin
            check(got_done && !got_tmo, "R3/R4/R5 completion seen", {got_done, got_tmo}, 2);
            check(result == model_word(k + 1), "R7 result word", result, model_word(k + 1));
        end else begin
            check(got_tmo && !got_done, "R8 timeout raised", {got_done, got_tmo}, 1);
        end
        @(negedge clk);
        check(!done && !tmo, "R7/R8 single-cycle pulse", {done, tmo}, 0);
        repeat (3 * RD) @(negedge clk);
        reads_at_end = rd_idx + 1;
        check(reads_at_end == exp_reads,
              inject ? "R9 start ignored, read count" : "R7/R8 read count",
              reads_at_end, exp_reads);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ce_n && oe_n && !done && !tmo, "R1 reset state", {ce_n, oe_n, done, tmo}, 12);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 1'b0, 16'h00A5, 20'h12345, 3, 1'b0); // R3 program, bit-7
        run_op(1'b0, 1'b0, 16'h1234, 20'h00010, 0, 1'b0); // R3 already done
        run_op(1'b1, 1'b0, 16'h0000, 20'hFFFFF, 5, 1'b0); // R4 erase, bit-7
        run_op(1'b0, 1'b1, 16'hC3C3, 20'h0AAAA, 4, 1'b0); // R5 program, toggle
        run_op(1'b1, 1'b1, 16'h0000, 20'h05555, 0, 1'b0); // R5 first read never ends
        run_op(1'b0, 1'b0, 16'h0080, 20'h00001, 20, 1'b0); // R8 timeout
        run_op(1'b1, 1'b1, 16'h0000, 20'h00002, 30, 1'b0); // R8 timeout, toggle
        run_op(1'b0, 1'b0, 16'h7F00, 20'h33333, 6, 1'b1); // R9 injected start
        for (int n = 0; n < 40; n++)
            run_op(1'($urandom), 1'($urandom), DW'($urandom), AW'($urandom),
                   int'($urandom_range(0, 14)), 1'($urandom_range(0, 3) == 0));
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule